// File: doc/BRIEF.md
# SHA-1 Challenge-Response MAC Engine

This block produces a 160-bit message authentication code from a single 512-bit SHA-1 block. The block is built inside the engine from a 64-bit secret, a 64-bit challenge written by the host, and fixed fill words. A 64-bit device identifier can optionally take the place of two of the fill words. The host writes the challenge as two 32-bit halves and pulses `start`, choosing with `use_id` whether the identifier goes into the block. It then waits for `done` and reads `mac`.

The compression runs one SHA-1 round per clock through a single 32-bit round datapath. A rolling window of sixteen schedule words supplies each round's input. The challenge register is wiped when each computation starts, so every request needs a fresh challenge. The secret enters only the hash datapath: no output port carries it and no path returns it to the host.

Top module: `sha1_mac_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `mac` is all zeros.
- R2: With `use_id`=0, the hashed block is built from big-endian words W0..W15. W0 is secret[63:32] and W1 is secret[31:0]. W2 is challenge[63:32] and W3 is challenge[31:0]. Each Wk for k=4..14 is 32'hA5A5A500 with k OR-ed into its low bits. W15 is 32'h00000200.
- R3: With `use_id`=1 the layout is the same as in R2, except that W4 is id[63:32] and W5 is id[31:0].
- R4: `mac` is the standard single-block SHA-1 digest of that block, {A+H0, B+H1, C+H2, D+H3, E+H4}, where A..E start from the SHA-1 initial values H0..H4.
- R5: A `start` seen while idle raises `busy` on the next cycle. `busy` stays high for exactly 80 cycles. `done` pulses high for one cycle in the first cycle after `busy` falls, and `mac` holds the new result in that cycle.
- R6: The challenge is cleared to zero when a computation starts. A later computation run without a new write hashes an all-zero challenge.
- R7: Challenge writes while `busy` is high are ignored.
- R8: A `start` while `busy` is high is ignored. The running computation still takes 80 cycles, and no second computation follows it.
- R9: If `chal_we` and `start` are both high in the same idle cycle, the computation uses the challenge held before that cycle and the write is discarded.
- R10: `mac` changes only in the cycle in which `done` is high.
- R11: `chal_hi`=1 writes `chal_wdata` to challenge[63:32]; `chal_hi`=0 writes it to challenge[31:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chal_we | input | 1 | Challenge half write strobe |
| chal_hi | input | 1 | Selects the upper (1) or lower (0) challenge half |
| chal_wdata | input | 32 | Challenge half data |
| start | input | 1 | Compute request |
| use_id | input | 1 | Put the device identifier into W4..W5 |
| secret | input | 64 | Stored secret, reaches only the hash |
| dev_id | input | 64 | Device identifier |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| mac | output | 160 | Result digest |

## Verification
A challenge write and a compute request can arrive in the same idle cycle. The bench drives both strobes on one clock edge. It expects a digest over the previously written challenge, and then a digest over an all-zero challenge on the next request made without a write. Writes and starts are also injected partway through a computation. Each is judged by the round count, by the absence of a restart, and by the challenge the following computation hashes.

// File: rtl/sha1_mac_engine.sv
module sha1_mac_engine #(
  parameter int          ROUNDS   = 80,
  parameter logic [31:0] PAD_BASE = 32'hA5A5_A500,
  parameter logic [31:0] LEN_WORD = 32'h0000_0200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chal_we,
  input  logic         chal_hi,
  input  logic [31:0]  chal_wdata,
  input  logic         start,
  input  logic         use_id,
  input  logic [63:0]  secret,
  input  logic [63:0]  dev_id,
  output logic         busy,
  output logic         done,
  output logic [159:0] mac
);
  localparam int CW = $clog2(ROUNDS);
  localparam logic [31:0] H0 = 32'h6745_2301;
  localparam logic [31:0] H1 = 32'hEFCD_AB89;
  localparam logic [31:0] H2 = 32'h98BA_DCFE;
  localparam logic [31:0] H3 = 32'h1032_5476;
  localparam logic [31:0] H4 = 32'hC3D2_E1F0;

  logic [31:0]   a, b, c, d, e;
  logic [31:0]   w [16];
  logic [CW-1:0] rnd;
  logic [63:0]   chal;
  logic [31:0]   f, kc, t_next, w_new;

  function automatic logic [31:0] blk_word(input int k, input logic [63:0] s,
                                           input logic [63:0] ch, input logic [63:0] id,
                                           input logic sel);
    case (k)
      0:  return s[63:32];
      1:  return s[31:0];
      2:  return ch[63:32];
      3:  return ch[31:0];
      4:  return sel ? id[63:32] : (PAD_BASE | 32'(k));
      5:  return sel ? id[31:0]  : (PAD_BASE | 32'(k));
      15: return LEN_WORD;
      default: return PAD_BASE | 32'(k);
    endcase
  endfunction

  always_comb begin
    if (rnd < CW'(20)) begin
      f = (b & c) | (~b & d);  kc = 32'h5A82_7999;
    end else if (rnd < CW'(40)) begin
      f = b ^ c ^ d;           kc = 32'h6ED9_EBA1;
    end else if (rnd < CW'(60)) begin
      f = (b & c) | (b & d) | (c & d); kc = 32'h8F1B_BCDC;
    end else begin
      f = b ^ c ^ d;           kc = 32'hCA62_C1D6;
    end
  end

  assign t_next = {a[26:0], a[31:27]} + f + e + kc + w[0];
  assign w_new  = {w[13][30:0] ^ w[8][30:0] ^ w[2][30:0] ^ w[0][30:0],
                   w[13][31] ^ w[8][31] ^ w[2][31] ^ w[0][31]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      mac  <= '0;
      chal <= '0;
      rnd  <= '0;
      a <= '0; b <= '0; c <= '0; d <= '0; e <= '0;
      for (int k = 0; k < 16; k++) w[k] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          rnd  <= '0;
          a <= H0; b <= H1; c <= H2; d <= H3; e <= H4;
          for (int k = 0; k < 16; k++) w[k] <= blk_word(k, secret, chal, dev_id, use_id);
          chal <= '0;
        end else if (chal_we) begin
          if (chal_hi) chal[63:32] <= chal_wdata;
          else         chal[31:0]  <= chal_wdata;
        end
      end else begin
        e <= d;
        d <= c;
        c <= {b[1:0], b[31:2]};
        b <= a;
        a <= t_next;
        for (int k = 0; k < 15; k++) w[k] <= w[k+1];
        w[15] <= w_new;
        rnd <= rnd + 1'b1;
        if (rnd == CW'(ROUNDS - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          mac  <= {t_next + H0, a + H1, {b[1:0], b[31:2]} + H2, c + H3, d + H4};
        end
      end
    end
  end
endmodule

module sha1_mac_engine_chk #(
  parameter int ROUNDS = 80
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [159:0] mac
);
  logic [7:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= busy ? bcnt + 1'b1 : '0;
  end

  a_r5_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r5_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < 8'(ROUNDS)));
  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_mac_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(mac));
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind sha1_mac_engine sha1_mac_engine_chk #(.ROUNDS(ROUNDS)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .mac(mac)
);

// File: tb/sha1_mac_engine_tb.sv
module sha1_mac_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         chal_we = 1'b0, chal_hi = 1'b0, start = 1'b0, use_id = 1'b0;
  logic [31:0]  chal_wdata = '0;
  logic [63:0]  secret = '0, dev_id = '0;
  logic         busy, done;
  logic [159:0] mac;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sha1_mac_engine dut_i (
    .clk(clk), .rst_n(rst_n), .chal_we(chal_we), .chal_hi(chal_hi),
    .chal_wdata(chal_wdata), .start(start), .use_id(use_id),
    .secret(secret), .dev_id(dev_id), .busy(busy), .done(done), .mac(mac)
  );

  function automatic logic [511:0] make_blk(input logic [63:0] s, input logic [63:0] ch,
                                            input logic [63:0] id, input logic sel);
    logic [511:0] blk;
    for (int k = 0; k < 16; k++) begin
      logic [31:0] wd;
      wd = 32'hA5A5_A500 | 32'(k);
      if (k == 0) wd = s[63:32];
      if (k == 1) wd = s[31:0];
      if (k == 2) wd = ch[63:32];
      if (k == 3) wd = ch[31:0];
      if (k == 4 && sel) wd = id[63:32];
      if (k == 5 && sel) wd = id[31:0];
      if (k == 15) wd = 32'h0000_0200;
      blk[511-32*k -: 32] = wd;
    end
    return blk;
  endfunction

  function automatic logic [31:0] rol(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] sha1_ref(input logic [511:0] blk);
    logic [31:0] w [80];
    logic [31:0] ha, hb, hc, hd, he, ff, kk, tt;
    for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 80; t++) w[t] = rol(w[t-3] ^ w[t-8] ^ w[t-14] ^ w[t-16], 1);
    ha = 32'h67452301; hb = 32'hEFCDAB89; hc = 32'h98BADCFE; hd = 32'h10325476; he = 32'hC3D2E1F0;
    for (int t = 0; t < 80; t++) begin
      if (t < 20)      begin ff = (hb & hc) | (~hb & hd);          kk = 32'h5A827999; end
      else if (t < 40) begin ff = hb ^ hc ^ hd;                    kk = 32'h6ED9EBA1; end
      else if (t < 60) begin ff = (hb & hc) | (hb & hd) | (hc & hd); kk = 32'h8F1BBCDC; end
      else             begin ff = hb ^ hc ^ hd;                    kk = 32'hCA62C1D6; end
      tt = rol(ha, 5) + ff + he + kk + w[t];
      he = hd; hd = hc; hc = rol(hb, 30); hb = ha; ha = tt;
    end
    return {ha + 32'h67452301, hb + 32'hEFCDAB89, hc + 32'h98BADCFE,
            hd + 32'h10325476, he + 32'hC3D2E1F0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [159:0] act,
                       input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_chal(input logic [63:0] v);
    @(negedge clk); chal_we = 1'b1; chal_hi = 1'b1; chal_wdata = v[63:32];
    @(negedge clk); chal_hi = 1'b0; chal_wdata = v[31:0];
    @(negedge clk); chal_we = 1'b0;
  endtask

  // start a computation; optional write and start injected while busy; optional
  // same-cycle write alongside start
  task automatic run(input logic sel, input logic [159:0] exp, input bit mid_wr,
                     input bit mid_st, input bit same_wr, input string req);
    int n;
    @(negedge clk);
    start = 1'b1; use_id = sel;
    if (same_wr) begin chal_we = 1'b1; chal_hi = 1'b1; chal_wdata = $urandom; end
    @(negedge clk);
    start = 1'b0; chal_we = 1'b0;
    check(busy === 1'b1, "R5 busy rise", {159'd0, busy}, 160'd1);
    n = 0;
    while (busy === 1'b1 && n < 200) begin
      n++;
      if (mid_wr && n == 10) begin chal_we = 1'b1; chal_hi = n[0]; chal_wdata = $urandom | 32'h1; end
      if (mid_wr && n == 12) begin chal_we = 1'b1; chal_hi = 1'b1; chal_wdata = 32'hDEAD_BEEF; end
      if (mid_st && n == 20) start = 1'b1;
      @(negedge clk);
      chal_we = 1'b0; start = 1'b0;
    end
    check(n == 80, "R5 busy length", 160'(n), 160'd80);
    check(done === 1'b1, "R5 done pulse", {159'd0, done}, 160'd1);
    check(mac === exp, req, mac, exp);
    @(negedge clk);
    check(done === 1'b0, "R5 done one cycle", {159'd0, done}, 160'd0);
    check(busy === 1'b0, "R8 no restart", {159'd0, busy}, 160'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0]  ch;
    logic [159:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && mac === '0, "R1 reset", mac, 160'd0);

    // R2 R4 R11 directed: fixed secret and challenge
    secret = 64'h0123_4567_89AB_CDEF;
    ch = 64'hFEDC_BA98_7654_3210;
    write_chal(ch);
    run(1'b0, sha1_ref(make_blk(secret, ch, dev_id, 1'b0)), 0, 0, 0, "R2 R4 R11 layout no id");

    // R6: challenge cleared by previous start
    run(1'b0, sha1_ref(make_blk(secret, 64'd0, dev_id, 1'b0)), 0, 0, 0, "R6 cleared challenge");

    // R3 with identifier
    dev_id = 64'h1122_3344_5566_7788;
    ch = 64'h0F0F_0F0F_F0F0_F0F0;
    write_chal(ch);
    run(1'b1, sha1_ref(make_blk(secret, ch, dev_id, 1'b1)), 0, 0, 0, "R3 R4 layout with id");

    // R7 writes and R8 start while busy
    ch = {$urandom, $urandom};
    write_chal(ch);
    run(1'b0, sha1_ref(make_blk(secret, ch, dev_id, 1'b0)), 1, 1, 0, "R8 start ignored while busy");
    run(1'b0, sha1_ref(make_blk(secret, 64'd0, dev_id, 1'b0)), 0, 0, 0, "R7 busy writes ignored");

    // R9 same-cycle write and start
    ch = {$urandom, $urandom};
    write_chal(ch);
    run(1'b1, sha1_ref(make_blk(secret, ch, dev_id, 1'b1)), 0, 0, 1, "R9 collision uses old challenge");
    run(1'b1, sha1_ref(make_blk(secret, 64'd0, dev_id, 1'b1)), 0, 0, 0, "R9 collision write discarded");

    // R10 mac holds while idle
    held = mac;
    repeat (5) @(negedge clk);
    check(mac === held, "R10 mac hold", mac, held);

    // random mix
    for (int i = 0; i < 8; i++) begin
      logic s;
      secret = {$urandom, $urandom};
      dev_id = {$urandom, $urandom};
      ch = {$urandom, $urandom};
      s = 1'($urandom);
      write_chal(ch);
      run(s, sha1_ref(make_blk(secret, ch, dev_id, s)), 0, 0, 0, "R2 R3 R4 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule